// File: doc/BRIEF.md
# VCO Coarse Band Calibration Engine

This block selects the coarse capacitor-bank setting of a ring VCO before the synthesizer closes its loop. A single-cycle start pulse, issued when the synthesizer is powered, begins the run. On that pulse the engine captures the integer and fractional tuning words and opens the loop. It also asserts a request that pins the VCO control voltage to a fixed reference. The coarse code then follows a binary search, most significant bit first.

For each trial code the engine waits a settling interval. It then counts rising edges of a prescaled VCO signal over a fixed window of reference-clock cycles and compares the count with a target derived from the integer tuning word. A raised coarse code adds capacitance, so the VCO frequency falls as the code rises. After the last bit the engine releases the reference pin, closes the loop, presents the final code and the captured divider words, and pulses done one cycle later. Fine tuning by the closed loop takes over from there.

The block has no data stream, so every pin is a plain control or status level. The prescaled VCO input is asynchronous and passes through a two-stage synchronizer before edge detection. The defaults assume a 2^8 prescaler, a 256-cycle window and an 8-cycle settling gap.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, `loop_open_o`, `vctl_pin_o` and `cal_done_o` are 0, and `coarse_code_o`, `div_int_o` and `div_frac_o` are all zero.
- R2: A `cal_start_i` pulse sampled while idle captures both tuning words. In the next cycle `loop_open_o` and `vctl_pin_o` are 1 and `coarse_code_o` is 4'b1000, the MSB trial.
- R3: Each search step keeps its trial bit only when the measured count is greater than or equal to the target. The final code is therefore the highest code whose count reaches the target, or 0 when no code does.
- R4: The target count is `ftw_int_i * WIN_CYC / 2^PRE_LOG2`. With the defaults this equals the captured integer word.
- R5: Each step takes SETTLE_CYC + WIN_CYC + 1 cycles: a settling gap, then a counting window of synchronized rising edges, then one decision cycle. `loop_open_o` falls exactly 4*(SETTLE_CYC+WIN_CYC+1) cycles after the start edge, which is 1060 cycles with the defaults.
- R6: When the loop closes, `vctl_pin_o` also falls, `coarse_code_o` shows the final code, and the divider outputs equal the captured words. `cal_done_o` is high for exactly one cycle, the cycle after `loop_open_o` falls.
- R7: A start pulse that arrives while a calibration is running has no effect. It does not restart the search or change its timing, and the divider outputs keep the words captured at the first start.
- R8: After done, the code and divider outputs hold their values until the next start, whatever the VCO input does.
- R9: A new start after done runs a full fresh calibration with the newly applied tuning words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_start_i | input | 1 | Single-cycle calibration request |
| ftw_int_i | input | INT_W | Integer divider tuning word |
| ftw_frac_i | input | FRAC_W | Fractional divider tuning word |
| vco_div_i | input | 1 | Prescaled VCO signal, asynchronous |
| loop_open_o | output | 1 | High while the loop is held open |
| vctl_pin_o | output | 1 | High while the VCO control is tied to the reference voltage |
| coarse_code_o | output | CODE_W | Capacitor-bank code (trial during search, final after) |
| div_int_o | output | INT_W | Latched integer divider value |
| div_frac_o | output | FRAC_W | Latched fractional divider value |
| cal_done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the following about the inputs:
- The prescaled VCO input stays high and stays low for at least one reference cycle each. This keeps its edge rate under one per two cycles, so the synchronizer never drops an edge and the count never exceeds the window length.
- The VCO frequency falls monotonically as the coarse code rises.

The stimulus meets both conditions with a phase-accumulator VCO model. Its rate per code is below one half and steps down with the code. Each code's count lands at least one edge clear of the target whatever the window phase, so every search decision is fixed in advance. Start pulses last one cycle, and are driven on the falling clock edge.

// File: rtl/vco_band_cal_pkg.sv
package vco_band_cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_SEARCH = 2'd1,
    CAL_CLOSE  = 2'd2
  } cal_state_e;

  typedef enum logic [1:0] {
    MEAS_IDLE   = 2'd0,
    MEAS_SETTLE = 2'd1,
    MEAS_COUNT  = 2'd2,
    MEAS_REPORT = 2'd3
  } meas_phase_e;
endpackage

// File: rtl/vco_band_edge_sync.sv
module vco_band_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  // sh_q[STAGES-1] is the last synchronizer stage, sh_q[STAGES] its history
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/vco_band_freq_counter.sv
module vco_band_freq_counter
  import vco_band_cal_pkg::*;
#(
  parameter int WIN_CYC    = 256,
  parameter int SETTLE_CYC = 8,
  parameter int CNT_W      = $clog2(WIN_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             rise_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int SPAN  = (WIN_CYC > SETTLE_CYC) ? WIN_CYC : SETTLE_CYC;
  localparam int TMR_W = (SPAN > 1) ? $clog2(SPAN) : 1;

  meas_phase_e      phase_q;
  logic [TMR_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= MEAS_IDLE;
      tmr_q   <= '0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      phase_q <= MEAS_SETTLE;
      tmr_q   <= '0;
    end else begin
      case (phase_q)
        MEAS_SETTLE: begin
          if (tmr_q == TMR_W'(SETTLE_CYC - 1)) begin
            phase_q <= MEAS_COUNT;
            tmr_q   <= '0;
            cnt_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        MEAS_COUNT: begin
          cnt_q <= cnt_q + CNT_W'(rise_i);
          if (tmr_q == TMR_W'(WIN_CYC - 1)) phase_q <= MEAS_REPORT;
          else                              tmr_q   <= tmr_q + 1'b1;
        end
        MEAS_REPORT: phase_q <= MEAS_IDLE;
        default:     phase_q <= MEAS_IDLE;
      endcase
    end
  end

  assign valid_o = (phase_q == MEAS_REPORT);
  assign count_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WIN_CYC)) else $error("edge count beyond window"); // R5
  AST_REPORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o) else $error("report lasted more than a cycle"); // R5
endmodule

// File: rtl/vco_band_sar.sv
module vco_band_sar #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              keep_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o
);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] trial_q;
  logic [CODE_W-1:0] probe_q;
  logic [CODE_W-1:0] settled;

  assign settled = keep_i ? trial_q : (trial_q & ~probe_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      probe_q <= '0;
    end else if (init_i) begin
      trial_q <= MSB_ONLY;
      probe_q <= MSB_ONLY;
    end else if (step_i && (probe_q != '0)) begin
      trial_q <= settled | (probe_q >> 1);
      probe_q <= probe_q >> 1;
    end
  end

  assign code_o = trial_q;
  assign last_o = probe_q[0];

  AST_PROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_q)) else $error("probe not one-hot"); // R3
  AST_CODE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !step_i) |=> $stable(trial_q)) else $error("code moved between steps"); // R3
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
  import vco_band_cal_pkg::*;
#(
  parameter int CODE_W      = 4,
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 16,
  parameter int WIN_CYC     = 256,
  parameter int SETTLE_CYC  = 8,
  parameter int PRE_LOG2    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start_i,
  input  logic [INT_W-1:0]  ftw_int_i,
  input  logic [FRAC_W-1:0] ftw_frac_i,
  input  logic              vco_div_i,
  output logic              loop_open_o,
  output logic              vctl_pin_o,
  output logic [CODE_W-1:0] coarse_code_o,
  output logic [INT_W-1:0]  div_int_o,
  output logic [FRAC_W-1:0] div_frac_o,
  output logic              cal_done_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam int TGT_W = INT_W + CNT_W;

  cal_state_e        state_q;
  logic              open_q;
  logic              done_q;
  logic [INT_W-1:0]  ftw_int_q;
  logic [FRAC_W-1:0] ftw_frac_q;
  logic [INT_W-1:0]  div_int_q;
  logic [FRAC_W-1:0] div_frac_q;

  logic              rise;
  logic              meas_valid;
  logic [CNT_W-1:0]  meas_count;
  logic              accept;
  logic              arm;
  logic              last_bit;
  logic              keep;
  logic [CODE_W-1:0] code;
  logic [TGT_W-1:0]  product;
  logic [TGT_W-1:0]  target;

  assign accept  = (state_q == CAL_IDLE) && cal_start_i;
  assign arm     = accept || (state_q == CAL_SEARCH && meas_valid && !last_bit);
  assign product = {{CNT_W{1'b0}}, ftw_int_q} * TGT_W'(WIN_CYC);
  assign target  = product >> PRE_LOG2;
  assign keep    = {{INT_W{1'b0}}, meas_count} >= target;

  vco_band_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(vco_div_i),
    .rise_o (rise)
  );

  vco_band_freq_counter #(
    .WIN_CYC   (WIN_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .CNT_W     (CNT_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (arm),
    .rise_i (rise),
    .valid_o(meas_valid),
    .count_o(meas_count)
  );

  vco_band_sar #(.CODE_W(CODE_W)) u_sar (
    .clk   (clk),
    .rst_n (rst_n),
    .init_i(accept),
    .step_i(state_q == CAL_SEARCH && meas_valid),
    .keep_i(keep),
    .code_o(code),
    .last_o(last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CAL_IDLE;
      open_q     <= 1'b0;
      done_q     <= 1'b0;
      ftw_int_q  <= '0;
      ftw_frac_q <= '0;
      div_int_q  <= '0;
      div_frac_q <= '0;
    end else begin
      done_q <= (state_q == CAL_CLOSE);
      case (state_q)
        CAL_IDLE: if (cal_start_i) begin
          state_q    <= CAL_SEARCH;
          open_q     <= 1'b1;
          ftw_int_q  <= ftw_int_i;
          ftw_frac_q <= ftw_frac_i;
        end
        CAL_SEARCH: if (meas_valid && last_bit) begin
          state_q    <= CAL_CLOSE;
          open_q     <= 1'b0;
          div_int_q  <= ftw_int_q;
          div_frac_q <= ftw_frac_q;
        end
        CAL_CLOSE: state_q <= CAL_IDLE;
        default:   state_q <= CAL_IDLE;
      endcase
    end
  end

  assign loop_open_o   = open_q;
  assign vctl_pin_o    = open_q;
  assign coarse_code_o = code;
  assign div_int_o     = div_int_q;
  assign div_frac_o    = div_frac_q;
  assign cal_done_o    = done_q;

  AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!open_q && !$past(open_q) && $past(open_q, 2))) else $error("done misplaced"); // R6
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(open_q) && !open_q) |-> ($stable(code) && $stable(div_int_q))) else $error("outputs moved while closed"); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != CAL_IDLE && cal_start_i) |=> $stable(ftw_int_q)) else $error("busy start captured"); // R7
endmodule

// File: tb/tb_vco_band_cal.sv
module tb_vco_band_cal;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start = 1'b0;
  logic [7:0]  ftw_int = '0;
  logic [15:0] ftw_frac = '0;
  logic        vco_div = 1'b0;
  logic        loop_open, vctl_pin, cal_done;
  logic [3:0]  coarse_code;
  logic [7:0]  div_int;
  logic [15:0] div_frac;

  int tests = 0;
  int fails = 0;
  int kval = 0;
  int tgt = 54;
  logic [15:0] acc = '0;

  localparam int CLOSE_N = 4 * (8 + 256 + 1) + 1;

  always #10 clk = ~clk;

  vco_band_cal dut (
    .clk(clk), .rst_n(rst_n), .cal_start_i(cal_start),
    .ftw_int_i(ftw_int), .ftw_frac_i(ftw_frac), .vco_div_i(vco_div),
    .loop_open_o(loop_open), .vctl_pin_o(vctl_pin), .coarse_code_o(coarse_code),
    .div_int_o(div_int), .div_frac_o(div_frac), .cal_done_o(cal_done)
  );

  // VCO model: rate falls with code; count = tgt + 3*(kval-code) + 1.5 per 256 cycles
  initial begin
    forever begin
      @(negedge clk);
      begin
        int inc;
        logic [16:0] s;
        inc = (2 * tgt + 6 * (kval - int'(coarse_code)) + 3) * 128;
        if (inc < 0) inc = 0;
        s = {1'b0, acc} + 17'(inc);
        acc = s[15:0];
        vco_div = s[16];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(loop_open == 0 && vctl_pin == 0, "R1 loop/pin", loop_open, 0);
    check(coarse_code == 0, "R1 code", coarse_code, 0);
    check(div_int == 0 && div_frac == 0, "R1 divider", div_int, 0);
    check(cal_done == 0, "R1 done", cal_done, 0);
  endtask

  task automatic run_cal(input int t_int, input int frac, input int k, input bit poke, input string tag);
    int n_open = 0, n_done = 0, done_cnt = 0, exp_code;
    kval = k;
    tgt = t_int;
    exp_code = (k < 0) ? 0 : ((k > 15) ? 15 : k);
    cal_start = 1'b1; ftw_int = 8'(t_int); ftw_frac = 16'(frac);
    @(negedge clk);
    cal_start = 1'b0;
    check(loop_open == 1 && vctl_pin == 1, {"R2 open ", tag}, loop_open, 1);
    check(coarse_code == 4'b1000, {"R2 msb trial ", tag}, coarse_code, 8);
    for (int n = 2; n <= CLOSE_N + 20; n++) begin
      @(negedge clk);
      cal_start = 1'b0;
      if (poke && n == 300) begin
        cal_start = 1'b1; ftw_int = 8'(t_int + 3); ftw_frac = ~16'(frac);
      end
      if (!loop_open && n_open == 0) n_open = n;
      if (cal_done) begin
        done_cnt++;
        if (n_done == 0) n_done = n;
      end
    end
    check(n_open == CLOSE_N, {"R5 close cycle ", tag}, n_open, CLOSE_N);
    check(n_done == CLOSE_N + 1 && done_cnt == 1, {"R6 done pulse ", tag}, n_done, CLOSE_N + 1);
    check(vctl_pin == 0, {"R6 pin released ", tag}, vctl_pin, 0);
    check(int'(coarse_code) == exp_code, {"R3 R4 final code ", tag}, coarse_code, exp_code);
    check(int'(div_int) == t_int, {"R6 R7 div int ", tag}, div_int, t_int);
    check(int'(div_frac) == frac, {"R6 R7 div frac ", tag}, div_frac, frac);
  endtask

  task automatic t_hold();
    logic [3:0] c0;
    logic [7:0] d0;
    c0 = coarse_code; d0 = div_int;
    kval = -5;
    repeat (400) @(negedge clk);
    check(coarse_code == c0, "R8 code held", coarse_code, c0);
    check(div_int == d0 && loop_open == 0, "R8 divider held", div_int, d0);
  endtask

  initial begin
    t_reset();
    run_cal(54, 16'h1234, 9, 1'b0, "k9");
    run_cal(54, 16'h0a0a, 15, 1'b0, "k15");
    run_cal(54, 16'h5555, -1, 1'b0, "none");
    run_cal(54, 16'h00ff, 0, 1'b0, "k0");
    t_hold();
    run_cal(54, 16'hbeef, 6, 1'b1, "R7 busy start");
    run_cal(60, 16'hc001, 5, 1'b0, "R9 new words");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule